// File: doc/BRIEF.md
# Fixed-Point Output Word Formatter

This block takes a 38-bit two's complement result from exact integer arithmetic and turns it into one output word. The word length and the number code are set by configuration. A shortened word is symmetrically rounded: ties go away from zero. A result that no longer fits the chosen length can be clamped to the nearest limit. If clamping is off, the result wraps. In both cases an overflow flag is raised. The value is then coded as two's complement, offset binary or signed magnitude.

The formatter sits at the end of a filter or accumulator chain and feeds a serializer or a parallel bus. The configuration inputs are sampled in the same cycle as the input strobe, so they may change between samples. Each accepted sample gives one output word, right-aligned, one clock later.

Top module: `fxp_word_fmt`

## Requirements
- R1: While reset is held and after it is released, before any sample is accepted, out_valid, out_ovf and every bit of out_data are 0.
- R2: out_valid is high exactly one cycle after a cycle with in_valid high, and low otherwise. out_data and out_ovf change only in the cycle after an accepted sample and hold their value while no sample arrives.
- R3: cfg_width selects the field length N: 0 gives 16, 1 gives 24, 2 gives 32, 3 gives 38. The field is formed from the N most significant input bits and is right-aligned in out_data (bits N-1..0). All bits of out_data above N-1 are 0.
- R4: With N = 38 and two's complement coding, out_data equals the input sample and out_ovf is 0.
- R5: With N < 38 the dropped bits are rounded to nearest, with ties away from zero. A positive value exactly halfway rounds up. A negative value exactly halfway rounds to the more negative neighbour. Example for N = 16: +5.5 LSB gives 0x0006, -5.5 LSB gives 0xFFFA, and -5.5 LSB plus one input LSB gives 0xFFFB.
- R6: A rounded value outside the signed N-bit range sets out_ovf. With cfg_sat_en = 1 the value is replaced by the nearest limit: the largest positive value (0 followed by N-1 ones) or the most negative value (1 followed by N-1 zeros).
- R7: With cfg_sat_en = 0, an out-of-range value keeps only its low N bits (it wraps), and out_ovf is still set. Example: a positive overflow at N = 16 in two's complement gives 0x8000.
- R8: cfg_enc selects the code. 0 and 3 give two's complement. 1 gives offset binary, which is the two's complement field with bit N-1 inverted. 2 gives signed magnitude, with the sign in bit N-1 (1 = negative) and the magnitude in bits N-2..0.
- R9: In signed magnitude, a field equal to the most negative two's complement value, whether from the input or from a wrap, becomes sign 1 with an all-ones magnitude (all N bits set), and out_ovf is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 38 | Two's complement input sample |
| cfg_width | input | 2 | Field length select (16/24/32/38) |
| cfg_enc | input | 2 | Number code select |
| cfg_sat_en | input | 1 | Clamp on overflow when 1, wrap when 0 |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 38 | Right-aligned formatted word, zero above the field |
| out_ovf | output | 1 | Overflow or signed-magnitude clamp occurred for this word |

## Verification
The rounding increment and the overflow handling can act in the same cycle. A positive input whose kept bits are already the largest field value, with dropped bits at or above one half, rounds up out of range. The bench drives such inputs at each shortened length. It checks that out_ovf is set and that the word is the positive limit with clamping on, and the wrapped most negative value with clamping off. The same wrapped value combined with signed-magnitude coding makes the wrap and the magnitude clamp meet, and is judged against an all-ones field.

// File: rtl/fxp_fmt_pkg.sv
// Package: shared code values for the fixed-point output word formatter.
// Assumes: the number code travels as a 2-bit field; value 3 is a spare
// that the formatter treats as two's complement.
package fxp_fmt_pkg;

    typedef enum logic [1:0] {
        ENC_TWOS     = 2'd0,
        ENC_OFFSET   = 2'd1,
        ENC_SIGNMAG  = 2'd2,
        ENC_TWOS_ALT = 2'd3
    } enc_e;

    localparam int NUM_LENS = 4;

endpackage

// File: rtl/fxp_round_sel.sv
// Module: fxp_round_sel
// Builds one rounded candidate per selectable field length and picks the
// one named by sel. Each candidate keeps the top N input bits and adds one
// when the dropped bits call for it: at or above half for a positive value,
// strictly above half for a negative one. Ties therefore go away from zero.
// The candidate is sign-extended to ACC_W+1 bits so that an increment past
// the positive limit stays visible. The module also supplies the field mask
// and the field sign-bit position for the later stages.
// Assumes: every length is between 2 and ACC_W. Purely combinational.
module fxp_round_sel #(
    parameter int ACC_W = 38,
    parameter int LEN0  = 16,
    parameter int LEN1  = 24,
    parameter int LEN2  = 32,
    parameter int LEN3  = 38
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [1:0]       sel,
    output logic [ACC_W:0]   rnd_val,
    output logic             rnd_ovf,
    output logic [ACC_W-1:0] fld_mask,
    output logic [ACC_W-1:0] fld_top
);

    localparam int NL = fxp_fmt_pkg::NUM_LENS;

    logic [ACC_W:0]   cand_a [NL];
    logic             ovf_a  [NL];
    logic [ACC_W-1:0] mask_a [NL];
    logic [ACC_W-1:0] top_a  [NL];

    for (genvar g = 0; g < NL; g++) begin : g_len
        localparam int N = (g == 0) ? LEN0 : (g == 1) ? LEN1 : (g == 2) ? LEN2 : LEN3;
        localparam int D = ACC_W - N;
        localparam logic [ACC_W-1:0] MASK = {ACC_W{1'b1}} >> D;
        localparam logic [ACC_W-1:0] TOPB = {{(ACC_W-1){1'b0}}, 1'b1} << (N - 1);

        logic [ACC_W:0]   cand;
        logic [ACC_W+1-N:0] hi;

        if (D == 0) begin : g_full
            // Full length: the sample passes through unchanged.
            assign cand = {acc[ACC_W-1], acc};
        end else begin : g_short
            logic [N-1:0] kept;
            logic         tie_bit;
            logic         below;
            logic         up;

            assign kept    = acc[ACC_W-1:D];
            assign tie_bit = acc[D-1];
            if (D > 1) begin : g_below
                assign below = |acc[D-2:0];
            end else begin : g_nobelow
                assign below = 1'b0;
            end
            // Round half away from zero: a negative exact tie stays at the floor.
            assign up   = tie_bit & (~acc[ACC_W-1] | below);
            assign cand = {{(ACC_W+1-N){kept[N-1]}}, kept} + {{ACC_W{1'b0}}, up};
        end

        // Field fits only if every bit from the field sign upward agrees.
        assign hi         = cand[ACC_W:N-1];
        assign cand_a[g]  = cand;
        assign ovf_a[g]   = ~((&hi) | ~(|hi));
        assign mask_a[g]  = MASK;
        assign top_a[g]   = TOPB;
    end

    // Pick the candidate and its field geometry for the configured length.
    always_comb begin
        rnd_val  = cand_a[sel];
        rnd_ovf  = ovf_a[sel];
        fld_mask = mask_a[sel];
        fld_top  = top_a[sel];
    end

endmodule

// File: rtl/fxp_sat_wrap.sv
// Module: fxp_sat_wrap
// Resolves an out-of-range rounded value. With clamping on, the value goes
// to the nearest limit, chosen by its sign. With clamping off, only the low
// field bits are kept. The result is an N-bit two's complement field, and
// every bit above the field is zero.
// Assumes: mask/topb describe the selected field. Purely combinational.
module fxp_sat_wrap #(
    parameter int ACC_W = 38
) (
    input  logic [ACC_W:0]   val,
    input  logic             ovf,
    input  logic             sat_en,
    input  logic [ACC_W-1:0] mask,
    input  logic [ACC_W-1:0] topb,
    output logic [ACC_W-1:0] fld
);

    // Clamp to a limit or truncate to the field, then clear bits above it.
    always_comb begin
        if (ovf && sat_en) begin
            fld = val[ACC_W] ? topb : (mask & ~topb);
        end else begin
            fld = val[ACC_W-1:0] & mask;
        end
    end

endmodule

// File: rtl/fxp_encode.sv
// Module: fxp_encode
// Re-codes an N-bit two's complement field.
// - Offset binary flips the field sign bit.
// - Signed magnitude keeps the sign in the field top bit and negates
//   negative values into the lower bits.
// - The most negative field has no signed-magnitude twin. It becomes the
//   largest negative magnitude and is flagged.
// Assumes: bits of w above the field are zero. Purely combinational.
module fxp_encode #(
    parameter int ACC_W = 38
) (
    input  logic [ACC_W-1:0] w,
    input  logic [ACC_W-1:0] mask,
    input  logic [ACC_W-1:0] topb,
    input  logic [1:0]       enc,
    output logic [ACC_W-1:0] code,
    output logic             sm_ovf
);

    import fxp_fmt_pkg::*;

    logic             neg;
    logic             is_min;
    logic [ACC_W-1:0] mag;

    // Field sign, most-negative detect and negated magnitude.
    always_comb begin
        neg    = |(w & topb);
        is_min = (w == topb);
        mag    = (~w + {{(ACC_W-1){1'b0}}, 1'b1}) & mask & ~topb;
    end

    // Apply the selected number code.
    always_comb begin
        sm_ovf = 1'b0;
        case (enc_e'(enc))
            ENC_OFFSET:  code = w ^ topb;
            ENC_SIGNMAG: begin
                if (!neg) begin
                    code = w;
                end else if (is_min) begin
                    code   = mask;
                    sm_ovf = 1'b1;
                end else begin
                    code = topb | mag;
                end
            end
            default:     code = w;
        endcase
    end

endmodule

// File: rtl/fxp_word_fmt.sv
// Module: fxp_word_fmt (top)
// Fixed-point output word formatter. Rounding, overflow resolution and
// coding work combinationally on the incoming sample and the configuration
// of the same cycle. One register stage follows, so the latency is one cycle.
// Output registers load only on an accepted sample and hold otherwise.
// Assumes: synchronous active-low reset; configuration is valid whenever
// in_valid is high.
module fxp_word_fmt #(
    parameter int ACC_W = 38,
    parameter int LEN0  = 16,
    parameter int LEN1  = 24,
    parameter int LEN2  = 32,
    parameter int LEN3  = 38
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ACC_W-1:0] in_data,
    input  logic [1:0]       cfg_width,
    input  logic [1:0]       cfg_enc,
    input  logic             cfg_sat_en,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_data,
    output logic             out_ovf
);

    import fxp_fmt_pkg::*;

    logic [ACC_W:0]   rnd_val;
    logic             rnd_ovf;
    logic [ACC_W-1:0] fld_mask;
    logic [ACC_W-1:0] fld_top;
    logic [ACC_W-1:0] clamp_val;
    logic [ACC_W-1:0] enc_val;
    logic             enc_ovf;
    logic [ACC_W-1:0] mask_q;

    fxp_round_sel #(
        .ACC_W(ACC_W), .LEN0(LEN0), .LEN1(LEN1), .LEN2(LEN2), .LEN3(LEN3)
    ) i_round (
        .acc      (in_data),
        .sel      (cfg_width),
        .rnd_val  (rnd_val),
        .rnd_ovf  (rnd_ovf),
        .fld_mask (fld_mask),
        .fld_top  (fld_top)
    );

    fxp_sat_wrap #(.ACC_W(ACC_W)) i_sat (
        .val    (rnd_val),
        .ovf    (rnd_ovf),
        .sat_en (cfg_sat_en),
        .mask   (fld_mask),
        .topb   (fld_top),
        .fld    (clamp_val)
    );

    fxp_encode #(.ACC_W(ACC_W)) i_enc (
        .w      (clamp_val),
        .mask   (fld_mask),
        .topb   (fld_top),
        .enc    (cfg_enc),
        .code   (enc_val),
        .sm_ovf (enc_ovf)
    );

    // Output stage: strobe every cycle, data and flag only on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ovf   <= 1'b0;
            mask_q    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= enc_val;
                out_ovf  <= rnd_ovf | enc_ovf;
                mask_q   <= fld_mask;
            end
        end
    end

    // R2
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_ovf)));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & ~mask_q) == '0));

    // R4
    full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_width == 2'd3 && cfg_enc == ENC_TWOS)
        |=> (out_data == $past(in_data) && !out_ovf));

    // R6
    sat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_sat_en && cfg_enc == ENC_TWOS && rnd_ovf)
        |=> (out_ovf && (out_data == ($past(rnd_val[ACC_W]) ? $past(fld_top)
                                                             : $past(fld_mask & ~fld_top)))));

    // R7
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_sat_en && rnd_ovf) |=> out_ovf);

    // R9
    sm_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_enc == ENC_SIGNMAG && clamp_val == fld_top)
        |=> (out_ovf && out_data == $past(fld_mask)));

endmodule

// File: tb/test_fxp_word_fmt.sv
// Directed bench for fxp_word_fmt with an independent arithmetic model.
module test_fxp_word_fmt;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [37:0] in_data;
    logic [1:0]  cfg_width;
    logic [1:0]  cfg_enc;
    logic        cfg_sat_en;
    logic        out_valid;
    logic [37:0] out_data;
    logic        out_ovf;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    fxp_word_fmt i_fxp_word_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .cfg_width  (cfg_width),
        .cfg_enc    (cfg_enc),
        .cfg_sat_en (cfg_sat_en),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ovf    (out_ovf)
    );

    // Independent model of the requirements using 64-bit integer arithmetic.
    task automatic model(input logic [37:0] d, input logic [1:0] w, input logic [1:0] e,
                         input logic s, output logic [37:0] od, output logic oo);
        int n;
        longint v, q, f, half, r, mx, mn, msk;
        longint u;
        n   = (w == 2'd0) ? 16 : (w == 2'd1) ? 24 : (w == 2'd2) ? 32 : 38;
        v   = $signed(d);
        if (n == 38) begin
            r = v;
        end else begin
            q    = v >>> (38 - n);
            f    = v - (q <<< (38 - n));
            half = 64'sd1 <<< (37 - n);
            r    = q + ((v >= 0) ? ((f >= half) ? 1 : 0) : ((f > half) ? 1 : 0));
        end
        mx  = (64'sd1 <<< (n - 1)) - 1;
        mn  = -mx - 1;
        msk = (64'sd1 <<< n) - 1;
        oo  = (r > mx) || (r < mn);
        if (oo) begin
            if (s) r = (r > 0) ? mx : mn;
            else begin
                r = r & msk;
                if (r > mx) r = r - (64'sd1 <<< n);
            end
        end
        u = r & msk;
        if (e == 2'd1) u = u ^ (64'sd1 <<< (n - 1));
        else if (e == 2'd2) begin
            if (r == mn) begin u = msk; oo = 1'b1; end
            else if (r < 0) u = (64'sd1 <<< (n - 1)) | (-r);
        end
        od = u[37:0];
    endtask

    task automatic chk(input string tag, input logic [37:0] gd, input logic [37:0] ed,
                       input logic go, input logic eo);
        n_chk++;
        if (gd !== ed || go !== eo) begin
            n_fail++;
            $display("FAIL %s: actual data=%h ovf=%b expected data=%h ovf=%b", tag, gd, go, ed, eo);
        end
    endtask

    task automatic chk_bit(input string tag, input logic g, input logic e);
        n_chk++;
        if (g !== e) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, g, e);
        end
    endtask

    // One sample: drive at a falling edge, sample one cycle later.
    task automatic apply(input logic [37:0] d, input logic [1:0] w, input logic [1:0] e,
                         input logic s);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; cfg_width = w; cfg_enc = e; cfg_sat_en = s;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic apply_lit(input string tag, input logic [37:0] d, input logic [1:0] w,
                             input logic [1:0] e, input logic s,
                             input logic [37:0] ed, input logic eo);
        apply(d, w, e, s);
        chk_bit({tag, " valid"}, out_valid, 1'b1);
        chk(tag, out_data, ed, out_ovf, eo);
    endtask

    task automatic apply_mdl(input string tag, input logic [37:0] d, input logic [1:0] w,
                             input logic [1:0] e, input logic s);
        logic [37:0] ed;
        logic eo;
        model(d, w, e, s, ed, eo);
        apply(d, w, e, s);
        chk(tag, out_data, ed, out_ovf, eo);
    endtask

    task automatic t_reset;
        // R1: outputs clear during reset and right after release.
        chk("R1 in reset", out_data, 38'd0, out_ovf, 1'b0);
        chk_bit("R1 valid in reset", out_valid, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", out_data, 38'd0, out_ovf, 1'b0);
        chk_bit("R1 valid after release", out_valid, 1'b0);
    endtask

    task automatic t_full;
        // R4 and R3: full length passes the sample unchanged.
        apply_lit("R4 pos", 38'h12_3456_789A, 2'd3, 2'd0, 1'b1, 38'h12_3456_789A, 1'b0);
        apply_lit("R4 neg", 38'h2F_EDCB_A987, 2'd3, 2'd0, 1'b0, 38'h2F_EDCB_A987, 1'b0);
        apply_lit("R3 top16", 38'h12_3400_0000, 2'd0, 2'd0, 1'b0, 38'h0_48D0, 1'b0);
    endtask

    task automatic t_round;
        // R5: ties away from zero, non-ties to nearest, at N=16.
        apply_lit("R5 pos tie", (38'd5 << 22) | (38'd1 << 21), 2'd0, 2'd0, 1'b0, 38'h0_0006, 1'b0);
        apply_lit("R5 pos below", (38'd5 << 22) | ((38'd1 << 21) - 38'd1), 2'd0, 2'd0, 1'b0,
                  38'h0_0005, 1'b0);
        apply_lit("R5 neg tie", 38'(-64'sd23068672), 2'd0, 2'd0, 1'b0, 38'h0_FFFA, 1'b0);
        apply_lit("R5 neg above", 38'(-64'sd23068671), 2'd0, 2'd0, 1'b0, 38'h0_FFFB, 1'b0);
        apply_lit("R5 tie N24", (38'd7 << 14) | (38'd1 << 13), 2'd1, 2'd0, 1'b0, 38'h00_0008, 1'b0);
        apply_lit("R5 tie N32", (38'd9 << 6) | (38'd1 << 5), 2'd2, 2'd0, 1'b0, 38'h0000_000A, 1'b0);
    endtask

    task automatic t_sat_wrap;
        // R6 and R7: rounding pushes the largest positive field out of range.
        apply_lit("R6 sat N16", {1'b0, {37{1'b1}}}, 2'd0, 2'd0, 1'b1, 38'h0_7FFF, 1'b1);
        apply_lit("R7 wrap N16", {1'b0, {37{1'b1}}}, 2'd0, 2'd0, 1'b0, 38'h0_8000, 1'b1);
        apply_lit("R6 sat N24", {1'b0, {37{1'b1}}}, 2'd1, 2'd0, 1'b1, 38'h7F_FFFF, 1'b1);
        apply_lit("R7 wrap N32", {1'b0, {37{1'b1}}}, 2'd2, 2'd0, 1'b0, 38'h8000_0000, 1'b1);
        apply_lit("R6 sat offset", {1'b0, {37{1'b1}}}, 2'd0, 2'd1, 1'b1, 38'h0_FFFF, 1'b1);
        apply_lit("R9 wrap signmag", {1'b0, {37{1'b1}}}, 2'd0, 2'd2, 1'b0, 38'h0_FFFF, 1'b1);
    endtask

    task automatic t_enc;
        // R8: the same value under each code.
        apply_lit("R8 twos neg", 38'(-64'sd12582912), 2'd0, 2'd0, 1'b0, 38'h0_FFFD, 1'b0);
        apply_lit("R8 offs neg", 38'(-64'sd12582912), 2'd0, 2'd1, 1'b0, 38'h0_7FFD, 1'b0);
        apply_lit("R8 smag neg", 38'(-64'sd12582912), 2'd0, 2'd2, 1'b0, 38'h0_8003, 1'b0);
        apply_lit("R8 spare neg", 38'(-64'sd12582912), 2'd0, 2'd3, 1'b0, 38'h0_FFFD, 1'b0);
        apply_lit("R8 offs pos", 38'd3 << 22, 2'd0, 2'd1, 1'b0, 38'h0_8003, 1'b0);
        apply_lit("R8 smag pos", 38'd3 << 22, 2'd0, 2'd2, 1'b0, 38'h0_0003, 1'b0);
    endtask

    task automatic t_sm_min;
        // R9: most negative value in signed magnitude.
        apply_lit("R9 twos min", 38'h20_0000_0000, 2'd0, 2'd0, 1'b0, 38'h0_8000, 1'b0);
        apply_lit("R9 smag min N16", 38'h20_0000_0000, 2'd0, 2'd2, 1'b1, 38'h0_FFFF, 1'b1);
        apply_lit("R9 smag min N38", 38'h20_0000_0000, 2'd3, 2'd2, 1'b0, 38'h3F_FFFF_FFFF, 1'b1);
    endtask

    task automatic t_hold;
        // R2: no sample means no strobe and held data.
        logic [37:0] keep_d;
        logic keep_o;
        apply_lit("R2 load", {1'b0, {37{1'b1}}}, 2'd0, 2'd0, 1'b0, 38'h0_8000, 1'b1);
        keep_d = out_data; keep_o = out_ovf;
        in_data = 38'h15_5555_5555; cfg_enc = 2'd1;
        repeat (3) begin
            @(negedge clk);
            chk_bit("R2 idle valid", out_valid, 1'b0);
            chk("R2 idle hold", out_data, keep_d, out_ovf, keep_o);
        end
    endtask

    task automatic t_stream;
        // R2: back-to-back samples each appear one cycle later.
        logic [37:0] pd;
        logic [1:0] pw, pe;
        logic ps, have;
        logic [37:0] ed;
        logic eo;
        have = 1'b0; pd = '0; pw = '0; pe = '0; ps = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            if (have) begin
                model(pd, pw, pe, ps, ed, eo);
                chk_bit("R2 stream valid", out_valid, 1'b1);
                chk("R2 stream data", out_data, ed, out_ovf, eo);
            end
            pd = {$urandom(), $urandom()} & 38'h3F_FFFF_FFFF;
            pw = 2'($urandom()); pe = 2'($urandom()); ps = 1'($urandom());
            in_valid = 1'b1; in_data = pd; cfg_width = pw; cfg_enc = pe; cfg_sat_en = ps;
            have = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        model(pd, pw, pe, ps, ed, eo);
        chk("R2 stream last", out_data, ed, out_ovf, eo);
    endtask

    task automatic t_sweep;
        // R3 R5 R6 R7 R8 R9: mixed sweep against the model, ties included.
        logic [37:0] d;
        logic [1:0] w;
        int dd;
        for (int i = 0; i < 400; i++) begin
            d  = {$urandom(), $urandom()} & 38'h3F_FFFF_FFFF;
            w  = 2'($urandom());
            dd = (w == 2'd0) ? 22 : (w == 2'd1) ? 14 : 6;
            if (i % 4 == 1 && w != 2'd3) d = (d & ~((38'd1 << dd) - 38'd1)) | (38'd1 << (dd - 1));
            if (i % 8 == 3) d = {1'b0, {37{1'b1}}};
            if (i % 16 == 5) d = 38'h20_0000_0000;
            apply_mdl("R8 sweep", d, w, 2'($urandom()), 1'($urandom()));
        end
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        cfg_width = '0; cfg_enc = '0; cfg_sat_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_full();
        t_round();
        t_sat_wrap();
        t_enc();
        t_sm_min();
        t_hold();
        t_stream();
        t_sweep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule